// File: doc/BRIEF.md
# Squelching 1:4 Serial Deserializer

This block turns a recovered serial bit stream into 4-bit parallel words. It runs on a single fast clock. A bit-clock enable marks each serial bit period, and a free-running phase counter divides that enable by four to set the word boundaries. The first bit of each group of four is placed in the most significant position of the word. The block makes no attempt to find a frame boundary, so downstream framing logic must realign the words.

While either loss-of-signal or loss-of-sync is raised, the parallel output is forced to zero. The word strobe keeps its steady cadence throughout, and the phase counter never stops or restarts. Real data returns with the first word whose four bits were all collected with both flags low.

A matching 4:1 serializer shares the same phase counter. It lets a loopback of the serial output into the serial input confirm that bit ordering survives any bit offset.

Top module: `deser_1to4_squelch`

## Requirements
- R1: Each emitted word holds the last four serial bits sampled on bit-enable cycles. The earliest of them is in bit 3 and the latest in bit 0.
- R2: The serializer captures `tx_word` on the fourth bit-enable cycle of each group. Over the next four bit periods it drives bit 3 first and bit 0 last on `tx_bit`. `tx_bit` changes only on bit-enable cycles.
- R3: In every cycle after a clock edge at which `rx_los` or `rx_unlocked` was high, `rx_word` is zero.
- R4: `rx_word_vld` is high for exactly one cycle after every fourth bit-enable cycle counted from reset, whether or not a loss flag is high.
- R5: A word whose collection window contains a loss flag is emitted as zero. The window runs from the cycle after the previous word edge through the word edge itself. The first word whose whole window is free of both flags carries real data.
- R6: After reset, `rx_word` is zero, `rx_word_vld` is low and `tx_bit` is low.
- R7: `rx_word_vld` is low in every cycle that does not follow a fourth bit-enable cycle, so the word rate is one quarter of the bit rate.
- R8: With no loss flag present, `rx_word` changes only in the cycle where `rx_word_vld` is high.
- R9: When `tx_bit` is looped back to `rx_bit` through a delay of 0 to 4 bit periods, each received word equals the transmitted bit stream shifted by that delay, in unchanged order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | High for one cycle per serial bit period |
| rx_bit | input | 1 | Serial receive data, sampled when `bit_en` is high |
| rx_los | input | 1 | Loss-of-signal flag; high forces the output to zero |
| rx_unlocked | input | 1 | Loss-of-sync flag; high forces the output to zero |
| tx_word | input | 4 | Parallel word for the serializer, captured at each word boundary |
| rx_word | output | 4 | Registered parallel receive word, first bit in bit 3 |
| rx_word_vld | output | 1 | One-cycle word strobe, once per four bit periods |
| tx_bit | output | 1 | Serial transmit data, bit 3 first |

## Verification
Suppose the word-phase counter slipped or were reset during squelch. The strobe would then fall off its four-bit cadence within one word. The loopback words would also appear rotated relative to the bench's bit-offset prediction. A taint flag that failed to clear would leave a zero word in place of the first clean word after the flags drop. A flag that failed to set would let a partly corrupted word leak out at the next strobe. Either fault shows within four bit periods. A reversed shift direction in either path breaks the ordering check on the very first word.

// File: rtl/deser_pkg.sv
package deser_pkg;

    // Whether the word now being gathered saw a loss flag.
    typedef enum logic {
        WORD_CLEAN   = 1'b0,
        WORD_TAINTED = 1'b1
    } taint_e;

endpackage

// File: rtl/word_phase_ctr.sv
module word_phase_ctr #(
    parameter int WORD_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    output logic last_bit
);
    localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (bit_en) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_bit = bit_en && (cnt_q == LAST);
endmodule

// File: rtl/deser_shift.sv
module deser_shift #(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    output logic [WORD_W-1:0] full_word
);
    logic [WORD_W-2:0] sh_d, sh_q;

    // Word formed by the held bits plus the bit arriving now; oldest bit on top.
    assign full_word = {sh_q, rx_bit};

    always_comb begin
        sh_d = sh_q;
        if (bit_en) sh_d = full_word[WORD_W-2:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              last_bit,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_bit
);
    logic [WORD_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (last_bit)    sh_d = tx_word;
        else if (bit_en) sh_d = {sh_q[WORD_W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign tx_bit = sh_q[WORD_W-1];
endmodule

// File: rtl/deser_1to4_squelch.sv
module deser_1to4_squelch
    import deser_pkg::*;
#(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              rx_los,
    input  logic              rx_unlocked,
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_word_vld,
    output logic              tx_bit
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              vld;
        taint_e            taint;
    } out_st_t;

    logic              last_bit;
    logic [WORD_W-1:0] full_word;
    logic              loss;
    logic              tainted;
    out_st_t           st_d, st_q;

    word_phase_ctr #(.WORD_W(WORD_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .last_bit (last_bit)
    );

    deser_shift #(.WORD_W(WORD_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .rx_bit    (rx_bit),
        .full_word (full_word)
    );

    ser_shift #(.WORD_W(WORD_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .last_bit (last_bit),
        .tx_word  (tx_word),
        .tx_bit   (tx_bit)
    );

    assign loss    = rx_los || rx_unlocked;
    assign tainted = (st_q.taint == WORD_TAINTED) || loss;

    always_comb begin
        st_d     = st_q;
        st_d.vld = last_bit;
        if (last_bit) begin
            // Word boundary: publish, or squelch if any flag touched the window.
            st_d.word  = tainted ? '0 : full_word;
            st_d.taint = WORD_CLEAN;
        end else if (loss) begin
            st_d.word  = '0;
            st_d.taint = WORD_TAINTED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.word  <= '0;
            st_q.vld   <= 1'b0;
            st_q.taint <= WORD_CLEAN;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_word     = st_q.word;
    assign rx_word_vld = st_q.vld;
endmodule

// File: rtl/deser_1to4_squelch_chk.sv
module deser_1to4_squelch_chk #(
    parameter int WORD_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              rx_los,
    input logic              rx_unlocked,
    input logic [WORD_W-1:0] tx_word,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_word_vld,
    input logic              tx_bit
);
    localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    // Checker-side count of bit periods since reset.
    logic [CNT_W-1:0] seen_q;
    logic             edge_now;

    always_ff @(posedge clk) begin
        if (!rst_n)      seen_q <= '0;
        else if (bit_en) seen_q <= (seen_q == LAST) ? '0 : seen_q + 1'b1;
    end

    assign edge_now = bit_en && (seen_q == LAST);

    p_strobe_cadence_r4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_now |=> rx_word_vld);

    p_no_extra_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_now |=> !rx_word_vld);

    p_squelch_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_los || rx_unlocked) |=> (rx_word == '0));

    p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_now && !rx_los && !rx_unlocked) |=> $stable(rx_word));

    p_tx_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_now |=> (tx_bit == $past(tx_word[WORD_W-1])));

    p_tx_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));
endmodule

bind deser_1to4_squelch deser_1to4_squelch_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .rx_los      (rx_los),
    .rx_unlocked (rx_unlocked),
    .tx_word     (tx_word),
    .rx_word     (rx_word),
    .rx_word_vld (rx_word_vld),
    .tx_bit      (tx_bit)
);

// File: tb/tb_deser_1to4_squelch.sv
module tb_deser_1to4_squelch;
    localparam int          OFF      = 3;       // loopback bit offset, 0..4
    localparam logic [2:0]  OFF3     = 3'(OFF);
    localparam int unsigned SEED     = 32'd24681;
    localparam int          WD_LIMIT = 100000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_en;
    logic       rnd_bit;
    logic       rx_bit;
    logic       rx_los;
    logic       rx_unlocked;
    logic [3:0] tx_word;
    logic [3:0] rx_word;
    logic       rx_word_vld;
    logic       tx_bit;
    logic       lb;

    always #4 clk = ~clk;   // 125 MHz

    // Loopback delay line: tap[k] is the transmit bit k bit periods ago.
    logic [7:0] dly = '0;
    logic [8:0] tap;
    assign tap    = {dly, tx_bit};
    assign rx_bit = lb ? tap[OFF3] : rnd_bit;
    always @(posedge clk) if (bit_en) dly <= {dly[6:0], tx_bit};

    deser_1to4_squelch dut (
        .clk (clk), .rst_n (rst_n), .bit_en (bit_en), .rx_bit (rx_bit),
        .rx_los (rx_los), .rx_unlocked (rx_unlocked), .tx_word (tx_word),
        .rx_word (rx_word), .rx_word_vld (rx_word_vld), .tx_bit (tx_bit)
    );

    // Values seen by the design at the last rising edge.
    logic       s_rst, s_en, s_rx, s_loss, s_tx, s_lb;
    logic [3:0] s_txw;
    always @(posedge clk) begin
        s_rst  <= rst_n;
        s_en   <= bit_en;
        s_rx   <= rx_bit;
        s_loss <= rx_los | rx_unlocked;
        s_tx   <= tx_bit;
        s_txw  <= tx_word;
        s_lb   <= lb;
    end

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model state.
    logic [1:0]  m_cnt;
    logic [3:0]  m_hist;
    logic [3:0]  m_word;
    logic [3:0]  m_txsh;
    logic [15:0] txs;
    logic        m_bad;
    logic        m_resume;
    int          lb_bits;
    int          tot_bits;

    function automatic logic [3:0] shift_in(input logic [3:0] h, input logic b);
        return {h[2:0], b};
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_hist = '0; m_word = '0; m_txsh = '0; txs = '0;
        m_bad = 1'b0; m_resume = 1'b0; lb_bits = 0; tot_bits = 0;
    endtask

    task automatic step();
        logic       complete, badnow, exp_vld;
        logic [3:0] nh;
        string      tag;
        complete = 1'b0;
        nh       = m_hist;
        if (!s_rst) begin
            model_reset();
            return;
        end
        if (s_en) begin
            chk(s_tx == m_txsh[3], "R2 tx bit order", {15'd0, s_tx}, {15'd0, m_txsh[3]});
            txs = {txs[14:0], m_txsh[3]};
            nh  = shift_in(m_hist, s_rx);
            complete = (m_cnt == 2'd3);
            m_txsh   = complete ? s_txw : {m_txsh[2:0], 1'b0};
            m_hist   = nh;
            m_cnt    = m_cnt + 2'd1;
            tot_bits++;
            lb_bits  = s_lb ? lb_bits + 1 : 0;
        end
        badnow  = m_bad | s_loss;
        exp_vld = complete;
        tag     = "R8 hold";
        if (complete) begin
            if (badnow) begin
                m_word = '0; m_resume = 1'b1; tag = "R3/R5 squelched word";
            end else begin
                m_word = nh;
                tag = m_resume ? "R5 first clean word" : "R1 word order";
                m_resume = 1'b0;
                if (s_lb && lb_bits >= 8 && tot_bits >= 16)
                    chk(rx_word == txs[OFF3 +: 4], "R9 loopback offset",
                        {12'd0, rx_word}, {12'd0, txs[OFF3 +: 4]});
            end
            m_bad = 1'b0;
        end else begin
            m_bad = badnow;
            if (s_loss) begin
                m_word = '0; tag = "R3 squelch";
            end
        end
        chk(rx_word_vld == exp_vld, exp_vld ? "R4 strobe cadence" : "R7 no extra strobe",
            {15'd0, rx_word_vld}, {15'd0, exp_vld});
        chk(rx_word == m_word, tag, {12'd0, rx_word}, {12'd0, m_word});
    endtask

    task automatic cycle(input int p_en, input int p_loss);
        @(negedge clk);
        step();
        bit_en      = ($urandom_range(99) < p_en);
        rnd_bit     = $urandom_range(1);
        rx_los      = ($urandom_range(99) < p_loss);
        rx_unlocked = ($urandom_range(99) < p_loss);
        tx_word     = 4'($urandom_range(15));
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(SEED));
        rst_n = 1'b0; bit_en = 1'b0; rnd_bit = 1'b0; rx_los = 1'b0;
        rx_unlocked = 1'b0; tx_word = 4'h0; lb = 1'b0;
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: reset state
        chk(rx_word == 4'h0, "R6 reset word", {12'd0, rx_word}, 16'd0);
        chk(rx_word_vld == 1'b0, "R6 reset strobe", {15'd0, rx_word_vld}, 16'd0);
        chk(tx_bit == 1'b0, "R6 reset tx", {15'd0, tx_bit}, 16'd0);

        // R1, R4: back-to-back bits, random data
        repeat (200) cycle(100, 0);
        // R1, R7, R8: sparse bit enables
        repeat (300) cycle(40, 0);
        // R3, R5: random loss flags mixed in
        repeat (400) cycle(70, 6);

        // Directed: loss only on a word-edge cycle, then a long burst.
        for (int k = 0; k < 8; k++) begin
            cycle(100, 0);
            if (m_cnt == 2'd3) rx_los = 1'b1;
        end
        for (int k = 0; k < 8; k++) begin
            cycle(100, 0);
            if (m_cnt == 2'd0 && k > 3) rx_unlocked = 1'b1;
        end
        for (int k = 0; k < 12; k++) begin
            cycle(100, 0);
            rx_unlocked = 1'b1;
            rx_los      = (k > 6);
        end
        repeat (20) cycle(100, 0);

        // R9: loopback with fixed offset, dense then sparse enables
        lb = 1'b1;
        repeat (300) cycle(100, 0);
        repeat (300) cycle(50, 0);
        lb = 1'b0;
        repeat (8) cycle(100, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule